// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block lets synchronous logic use a clockless static RAM. A host presents one request at a time: an address, a direction flag and, for writes, a data word. The sequencer then runs a complete memory cycle. It raises the chip enable and presents the address. It holds the active-low write strobe low for a programmed number of clocks. It keeps the address valid for a programmed number of clocks after the strobe rises. It finishes with a one-cycle done pulse, together with the read data when the cycle was a read.

All memory-side outputs come straight from flops, so the strobes carry no combinational glitches. The shared data bus is split into a driven word, an output-enable and a returned word; a pad ring or the bench joins them. The output-enable is high only during write cycles. Every timing interval is a parameter counted in clock cycles: address setup before the strobe falls, strobe low width, address hold after the strobe rises, and read access time. Each parameter must be at least 1.

Top module: `asram_cycle_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mem_en` is 0, `mem_we_n` is 1, `mem_wdata_oe` is 0, `mem_addr` is 0 and `rsp_done` is 0.
- R2: On a write (`req_write`=1), `mem_en` is high with the request address on `mem_addr` for exactly T_SETUP cycles before `mem_we_n` goes low.
- R3: On a write, `mem_we_n` stays low for exactly T_PULSE consecutive cycles.
- R4: On a write, after `mem_we_n` returns high, `mem_en` and the address stay asserted for exactly T_HOLD more cycles.
- R5: A write keeps `mem_en` high for T_SETUP+T_PULSE+T_HOLD cycles. `rsp_done` is high for exactly one cycle, the first cycle in which `mem_en` is low again.
- R6: On a read (`req_write`=0), `mem_en` is high for exactly T_ACCESS cycles. `mem_rdata` is captured at the clock edge that ends the last of them. The captured word appears on `rsp_rdata` during the one-cycle `rsp_done` pulse.
- R7: `mem_wdata_oe` is 1 only while `mem_en` is high in a write cycle. During a write, `mem_wdata` carries the request data for the whole cycle. `mem_wdata_oe` is never 1 in a read cycle.
- R8: A request is taken only when the sequencer is idle. A `req_valid` presented while a cycle is in progress, up to and including the done cycle's predecessor, is ignored: no further cycle starts and no memory word changes.
- R9: Whenever `mem_en` is low, `mem_addr` is 0, `mem_we_n` is 1 and `mem_wdata_oe` is 0.
- R10: `mem_we_n` is low only while `mem_en` is high. `mem_addr` does not change while `mem_en` stays high.
- R11: A read of an address returns the word most recently written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Captured read data, valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address, 0 when idle |
| mem_en | output | 1 | Memory enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DATA_W | Word driven onto the memory bus |
| mem_wdata_oe | output | 1 | Bus output-enable for mem_wdata |
| mem_rdata | input | DATA_W | Word returned from the memory bus |

## Verification
The hardest situation to reach from the ports is a read that samples one cycle too early. With an ideal memory model, an early sample would still return the right word. The bench memory therefore returns the inverted word until the bus has been enabled for T_ACCESS-1 full cycles, so a premature capture shows up as a data mismatch. Ignored requests are reached by holding `req_valid` high with a different address throughout a busy cycle. The bench drops it only in the done cycle, then checks that no new cycle starts and that the decoy address still holds its old word.

// File: rtl/asram_pkg.sv
package asram_pkg;

    // Phase of the memory cycle in progress.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACCESS = 3'd4
    } phase_e;

    // Per-cycle decisions taken by the phase controller.
    typedef struct packed {
        logic take;     // request accepted this edge
        logic finish;   // cycle ends this edge
        logic capture;  // sample memory read data this edge
        logic load;     // reload the interval timer
    } step_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval);
    endfunction

    function automatic logic is_write_phase(input phase_e p);
        return (p == PH_WSETUP) || (p == PH_WPULSE) || (p == PH_WHOLD);
    endfunction

endpackage

// File: rtl/asram_req_hold.sv
module asram_req_hold #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    // Bypass so the pin registers see the new request on the accept edge.
    assign cur_addr  = take ? in_addr  : addr_q;
    assign cur_wdata = take ? in_wdata : wdata_q;
endmodule

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_phase_fsm.sv
module asram_phase_fsm
    import asram_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_PULSE  = 3,
    parameter int T_HOLD   = 1,
    parameter int T_ACCESS = 3,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             last,
    output phase_e           phase_d,
    output step_t            step,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] LV_SETUP  = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LV_PULSE  = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] LV_HOLD   = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] LV_ACCESS = CNT_W'(T_ACCESS - 1);

    phase_e phase_q;

    always_comb begin
        phase_d  = phase_q;
        step     = '0;
        load_val = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    step.take = 1'b1;
                    step.load = 1'b1;
                    if (req_write) begin
                        phase_d  = PH_WSETUP;
                        load_val = LV_SETUP;
                    end else begin
                        phase_d  = PH_RACCESS;
                        load_val = LV_ACCESS;
                    end
                end
            end
            PH_WSETUP: begin
                if (last) begin
                    phase_d   = PH_WPULSE;
                    step.load = 1'b1;
                    load_val  = LV_PULSE;
                end
            end
            PH_WPULSE: begin
                if (last) begin
                    phase_d   = PH_WHOLD;
                    step.load = 1'b1;
                    load_val  = LV_HOLD;
                end
            end
            PH_WHOLD: begin
                if (last) begin
                    phase_d     = PH_IDLE;
                    step.finish = 1'b1;
                end
            end
            PH_RACCESS: begin
                if (last) begin
                    phase_d      = PH_IDLE;
                    step.finish  = 1'b1;
                    step.capture = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/asram_pin_drive.sv
module asram_pin_drive
    import asram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_d,
    input  step_t             step,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);
    logic active_d;
    logic drive_d;

    assign active_d = (phase_d != PH_IDLE);
    assign drive_d  = is_write_phase(phase_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr     <= '0;
            mem_en       <= 1'b0;
            mem_we_n     <= 1'b1;
            mem_wdata    <= '0;
            mem_wdata_oe <= 1'b0;
            rsp_rdata    <= '0;
            rsp_done     <= 1'b0;
        end else begin
            mem_en       <= active_d;
            mem_addr     <= active_d ? cur_addr : '0;
            mem_we_n     <= (phase_d != PH_WPULSE);
            mem_wdata_oe <= drive_d;
            mem_wdata    <= drive_d ? cur_wdata : '0;
            rsp_done     <= step.finish;
            if (step.capture) rsp_rdata <= mem_rdata;
        end
    end
endmodule

// File: rtl/asram_cycle_ctrl.sv
module asram_cycle_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int T_SETUP  = 2,
    parameter int T_PULSE  = 3,
    parameter int T_HOLD   = 1,
    parameter int T_ACCESS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned T_MAX = max4(T_SETUP, T_PULSE, T_HOLD, T_ACCESS);
    localparam int          CNT_W = int'(cnt_bits(T_MAX));

    phase_e            phase_d;
    step_t             step;
    logic [CNT_W-1:0]  load_val;
    logic              last;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    asram_phase_fsm #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD),
        .T_ACCESS(T_ACCESS),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .last     (last),
        .phase_d  (phase_d),
        .step     (step),
        .load_val (load_val)
    );

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (step.load),
        .load_val(load_val),
        .last    (last)
    );

    asram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .take     (step.take),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .cur_addr (cur_addr),
        .cur_wdata(cur_wdata)
    );

    asram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .phase_d     (phase_d),
        .step        (step),
        .cur_addr    (cur_addr),
        .cur_wdata   (cur_wdata),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_en      (mem_en),
        .mem_we_n    (mem_we_n),
        .mem_wdata   (mem_wdata),
        .mem_wdata_oe(mem_wdata_oe),
        .rsp_rdata   (rsp_rdata),
        .rsp_done    (rsp_done)
    );
endmodule

// File: rtl/asram_cycle_ctrl_chk.sv
module asram_cycle_ctrl_chk #(
    parameter int ADDR_W   = 10,
    parameter int T_SETUP  = 2,
    parameter int T_PULSE  = 3,
    parameter int T_HOLD   = 1,
    parameter int T_ACCESS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_en,
    input logic              mem_we_n,
    input logic              mem_wdata_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rsp_done
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] en_run;    // consecutive enabled cycles before this one
    logic [15:0] low_run;   // consecutive strobe-low cycles before this one
    logic [15:0] post_run;  // enabled strobe-high cycles after a pulse
    logic        wrote_q;   // current enabled stretch contained a pulse

    always_ff @(posedge clk) begin
        if (rst) begin
            en_run   <= '0;
            low_run  <= '0;
            post_run <= '0;
            wrote_q  <= 1'b0;
        end else begin
            en_run   <= !mem_en ? 16'd0 : ((en_run == SAT) ? SAT : en_run + 16'd1);
            low_run  <= mem_we_n ? 16'd0 : ((low_run == SAT) ? SAT : low_run + 16'd1);
            post_run <= (!mem_en || !mem_we_n) ? 16'd0
                      : (wrote_q ? ((post_run == SAT) ? SAT : post_run + 16'd1) : 16'd0);
            wrote_q  <= !mem_en ? 1'b0 : (wrote_q | !mem_we_n);
        end
    end

    p_setup_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> (en_run >= 16'(T_SETUP)));

    p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && mem_en) |-> (low_run >= 16'(T_PULSE)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && wrote_q) |-> (post_run >= 16'(T_HOLD)));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_access_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !wrote_q) |-> (en_run >= 16'(T_ACCESS)));

    p_oe_in_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wdata_oe |-> mem_en);

    p_idle_pins_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (mem_addr == '0 && mem_we_n && !mem_wdata_oe));

    p_strobe_en_r10: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_en);

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> $stable(mem_addr));
endmodule

bind asram_cycle_ctrl asram_cycle_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_HOLD  (T_HOLD),
    .T_ACCESS(T_ACCESS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_en      (mem_en),
    .mem_we_n    (mem_we_n),
    .mem_wdata_oe(mem_wdata_oe),
    .mem_addr    (mem_addr),
    .rsp_done    (rsp_done)
);

// File: tb/asram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module asram_cycle_ctrl_tb;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int TS = 2;
    localparam int TP = 3;
    localparam int TH = 1;
    localparam int TA = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic [AW-1:0] mem_addr;
    logic          mem_en;
    logic          mem_we_n;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_oe;
    logic [DW-1:0] mem_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    asram_cycle_ctrl #(
        .ADDR_W(AW), .DATA_W(DW),
        .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_ACCESS(TA)
    ) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we_n(mem_we_n),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata)
    );

    // ---------------- memory model with access-time emulation ----------
    logic [DW-1:0] ram    [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    int            en_age = 0;

    function automatic logic [DW-1:0] seed_word(input int a);
        return DW'(a * 40503) ^ 16'h5A5A;
    endfunction

    always @(posedge clk) begin
        en_age <= mem_en ? en_age + 1 : 0;
        if (mem_en && !mem_we_n && mem_wdata_oe) ram[mem_addr] <= mem_wdata;
    end

    // Correct data only once the bus has been enabled for TA-1 full cycles.
    assign mem_rdata = (mem_en && mem_we_n && en_age >= TA - 1) ? ram[mem_addr]
                                                                : ~ram[mem_addr];

    // ---------------- checking helpers ---------------------------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic txn(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit decoy);
        int s = 0, p = 0, h = 0, en_cnt = 0, guard = 0;
        bit seen_low = 0, oe_bad = 0, addr_bad = 0, data_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (decoy) begin
            req_write = 1'b1; req_addr = a ^ AW'(1); req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        while (!rsp_done && guard < 200) begin
            guard++;
            if (mem_en) begin
                en_cnt++;
                if (mem_addr != a) addr_bad = 1;
                if (wr && (!mem_wdata_oe || mem_wdata != d)) data_bad = 1;
                if (!wr && mem_wdata_oe) oe_bad = 1;
                if (!mem_we_n) begin seen_low = 1; p++; end
                else if (!seen_low) s++;
                else h++;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(rsp_done, "R5", "done seen", rsp_done, 1);
        check(!mem_en && mem_addr == '0 && mem_we_n && !mem_wdata_oe, "R9",
              "pins idle at done", {mem_en, mem_we_n, mem_wdata_oe}, 3'b010);
        check(!addr_bad, "R10", "address steady", addr_bad, 0);
        check(!oe_bad && !data_bad, "R7", "bus drive", {oe_bad, data_bad}, 0);
        if (wr) begin
            check(s == TS, "R2", "setup cycles", s, TS);
            check(p == TP, "R3", "strobe low cycles", p, TP);
            check(h == TH, "R4", "hold cycles", h, TH);
            check(en_cnt == TS + TP + TH, "R5", "enable cycles", en_cnt, TS + TP + TH);
            shadow[a] = d;
        end else begin
            check(p == 0, "R6", "no strobe on read", p, 0);
            check(en_cnt == TA, "R6", "access cycles", en_cnt, TA);
            check(rsp_rdata == shadow[a], "R11", "read data", rsp_rdata, shadow[a]);
        end
        @(negedge clk);
        check(!rsp_done, "R5", "done single cycle", rsp_done, 0);
        if (decoy) check(!mem_en, "R8", "decoy request started a cycle", mem_en, 0);
    endtask

    // ---------------- watchdog -----------------------------------------
    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // ---------------- main sequence ------------------------------------
    initial begin
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        bit            rw;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < DEPTH; i++) begin
            ram[i]    = seed_word(i);
            shadow[i] = seed_word(i);
        end
        repeat (3) @(negedge clk);
        check(!mem_en && mem_we_n && !mem_wdata_oe && mem_addr == '0 && !rsp_done,
              "R1", "pins in reset", {mem_en, mem_we_n, mem_wdata_oe, rsp_done}, 4'b0100);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_en && mem_we_n && !mem_wdata_oe && !rsp_done,
              "R1", "pins after reset", {mem_en, mem_we_n, mem_wdata_oe, rsp_done}, 4'b0100);

        // Directed corners.
        txn(1'b0, AW'(5), '0, 1'b0);                 // R6 read of seeded word
        txn(1'b1, '0, 16'hFFFF, 1'b0);               // R2 write lowest address
        txn(1'b1, '1, 16'h0000, 1'b0);               // R3 write highest address
        txn(1'b0, '0, '0, 1'b0);                     // R11 read back
        txn(1'b0, '1, '0, 1'b0);                     // R11 read back
        txn(1'b1, AW'(40), 16'hA5C3, 1'b1);          // R8 decoy during write
        txn(1'b0, AW'(41), '0, 1'b0);                // R8 decoy address untouched
        txn(1'b0, AW'(40), '0, 1'b1);                // R8 decoy during read
        txn(1'b0, AW'(41), '0, 1'b0);                // R8 still untouched
        txn(1'b0, AW'(40), '0, 1'b0);                // R11

        // Random traffic over a small window so reads hit written words.
        for (int k = 0; k < 60; k++) begin
            ra = AW'($urandom_range(0, 31));
            rd = DW'($urandom);
            rw = 1'($urandom_range(0, 1));
            txn(rw, ra, rd, ($urandom_range(0, 4) == 0) && (ra[0] == 1'b0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule